// File: doc/BRIEF.md
# Retired-Store Drain Buffer

This block holds stores between the execute stage and the L1 data cache. An executed store is allocated into the buffer with its address, data and reorder-buffer tag while it is still speculative. It cannot reach the cache in that state. Each pulse of the retire input promotes the oldest speculative entry to retired. Retired entries are then written to the cache, oldest first, through a valid/acknowledge request port. This port is decoupled from retirement, so a slow or stalled cache only fills the buffer and never holds up retirement itself.

A pipeline flush drops every speculative entry at once. The write side is pulled back to just after the youngest retired entry. Retired entries are architecturally complete, so they stay in the buffer and keep draining across the flush. A `drained` output reports that no retired store is still waiting, so that fences and similar operations can wait on it. When the buffer is full, the allocation port back-pressures the execute stage.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty: `req_valid` is 0, `drained` is 1 and `alloc_ready` is 1.
- R2: `req_valid` is asserted only while at least one retired entry is held. A speculative entry is never presented to the cache.
- R3: Retired entries leave in allocation order, with address, data and tag exactly as allocated. Each cycle with `req_valid` and `req_ack` both high removes exactly one entry.
- R4: When DEPTH entries are held, `alloc_ready` is 0. An `alloc_valid` in that cycle is dropped and adds no entry.
- R5: A `retire_valid` cycle marks the oldest speculative entry as retired. When no speculative entry is held, `retire_valid` has no effect. An entry allocated in the same cycle cannot be retired by that pulse.
- R6: A `flush` cycle discards all speculative entries. Entries already retired stay and are still sent to the cache in order.
- R7: When `retire_valid` and `flush` are high in the same cycle, the retire is applied first, so the retiring store survives the flush.
- R8: `alloc_ready` is 0 during a `flush` cycle, and no entry is allocated in that cycle.
- R9: `drained` is 1 exactly when no retired entry is held. Speculative entries do not clear it.
- R10: While `req_valid` is high and `req_ack` is low, the request stays valid and its address, data and tag stay unchanged into the next cycle.
- R11: With `req_ack` held low, the buffer keeps up to DEPTH retired entries and loses none of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Execute stage offers a store |
| alloc_ready | output | 1 | Buffer accepts the offered store this cycle |
| alloc_addr | input | ADDR_W | Store address |
| alloc_data | input | DATA_W | Store data |
| alloc_tag | input | TAG_W | Reorder-buffer tag of the store |
| retire_valid | input | 1 | Oldest speculative store has retired |
| flush | input | 1 | Pipeline flush: drop speculative stores |
| req_valid | output | 1 | Cache write request is pending |
| req_addr | output | ADDR_W | Address of the oldest retired store |
| req_data | output | DATA_W | Data of the oldest retired store |
| req_tag | output | TAG_W | Tag of the oldest retired store |
| req_ack | input | 1 | Cache accepts the pending request |
| drained | output | 1 | No retired store is waiting |

## Verification
The bench targets flushes that arrive while retired entries are still pending. A design that rewound too far would lose architecturally complete stores, and one that rewound too little would later send squashed stores to the cache. It pairs retire with flush in one cycle, since a design that handled the flush first would drop the store that was just retiring. It also tries allocation while the buffer is full and during a flush, and sends retire pulses with nothing speculative held; a design that miscounted here would show a corrupted or extra entry in the drain order. Long stretches with the acknowledge held low check that a full set of retired stores is held stable and then drains in order without duplicates.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // index width for a ring of the given depth (at least one bit)
  function automatic int sb_idx_w(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction

  // counter width able to hold the value depth itself
  function automatic int sb_cnt_w(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = sb_idx_w(DEPTH),
  localparam int CW = sb_cnt_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          retire_req,
  input  logic          flush,
  input  logic          drain_ack,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          has_retired
);
  logic [IW-1:0] head_q, head_d;
  logic [CW-1:0] ret_q, ret_d;
  logic [CW-1:0] spec_q, spec_d;
  logic          do_drain, do_retire;
  logic [IW:0]   tail_sum;
  logic [CW-1:0] total;

  // retired entries occupy [head, head+ret), speculative ones follow them
  always_comb begin
    do_drain  = drain_ack && (ret_q != '0);
    do_retire = retire_req && (spec_q != '0);

    head_d = head_q;
    if (do_drain) begin
      head_d = (head_q == IW'(DEPTH - 1)) ? '0 : head_q + IW'(1);
    end

    ret_d = ret_q;
    if (do_retire && !do_drain) ret_d = ret_q + CW'(1);
    else if (!do_retire && do_drain) ret_d = ret_q - CW'(1);

    // retire is applied before the flush removes what is left
    spec_d = spec_q;
    if (flush) spec_d = '0;
    else if (do_retire && !alloc_fire) spec_d = spec_q - CW'(1);
    else if (!do_retire && alloc_fire) spec_d = spec_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      ret_q  <= '0;
      spec_q <= '0;
    end else begin
      head_q <= head_d;
      ret_q  <= ret_d;
      spec_q <= spec_d;
    end
  end

  always_comb begin
    total    = ret_q + spec_q;
    tail_sum = {1'b0, head_q} + (IW + 1)'(total);
    if (tail_sum >= (IW + 1)'(DEPTH)) tail_sum = tail_sum - (IW + 1)'(DEPTH);
    tail_idx    = tail_sum[IW-1:0];
    head_idx    = head_q;
    full        = (total == CW'(DEPTH));
    has_retired = (ret_q != '0);
  end
endmodule

// File: rtl/sb_entry_ram.sv
module sb_entry_ram
  import sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int IW   = sb_idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_word,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] mem_q [DEPTH];

  // payload storage needs no reset: occupancy lives in the pointer logic
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IW'(g))) mem_q[g] <= wr_word;
    end
  end

  assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              retire_valid,
  input  logic              flush,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              req_ack,
  output logic              drained
);
  localparam int IW = sb_idx_w(DEPTH);
  localparam int EW = ADDR_W + DATA_W + TAG_W;

  logic          full, has_retired, alloc_fire;
  logic [IW-1:0] head_idx, tail_idx;
  logic [EW-1:0] rd_word;

  assign alloc_ready = !full && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;

  sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_req  (retire_valid),
    .flush       (flush),
    .drain_ack   (req_ack),
    .head_idx    (head_idx),
    .tail_idx    (tail_idx),
    .full        (full),
    .has_retired (has_retired)
  );

  sb_entry_ram #(.DEPTH(DEPTH), .W(EW)) u_ram (
    .clk     (clk),
    .wr_en   (alloc_fire),
    .wr_idx  (tail_idx),
    .wr_word ({alloc_addr, alloc_data, alloc_tag}),
    .rd_idx  (head_idx),
    .rd_word (rd_word)
  );

  assign req_valid = has_retired;
  assign drained   = !has_retired;
  assign {req_addr, req_data, req_tag} = rd_word;
endmodule

// File: rtl/store_buffer_chk.sv
module store_buffer_chk
  import sb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [ADDR_W-1:0] alloc_addr,
  input logic [DATA_W-1:0] alloc_data,
  input logic [TAG_W-1:0]  alloc_tag,
  input logic              retire_valid,
  input logic              flush,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic [TAG_W-1:0]  req_tag,
  input logic              req_ack,
  input logic              drained
);
  localparam int CW = sb_cnt_w(DEPTH) + 1;

  // occupancy as seen from the ports alone
  logic [CW-1:0] m_ret, m_spec;
  logic          m_rt, m_dr, m_al;

  assign m_rt = retire_valid && (m_spec != '0);
  assign m_dr = req_valid && req_ack;
  assign m_al = alloc_valid && alloc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ret  <= '0;
      m_spec <= '0;
    end else begin
      m_ret  <= m_ret + CW'(m_rt) - CW'(m_dr);
      m_spec <= flush ? '0 : (m_spec - CW'(m_rt) + CW'(m_al));
    end
  end

  AST_NO_SPEC_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (m_ret != '0)); // R2
  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_ret + m_spec) >= CW'(DEPTH)) |-> !alloc_ready); // R4
  AST_FLUSH_BLOCKS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready); // R8
  AST_DRAINED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drained == (m_ret == '0)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_tag))); // R10
  AST_RETIRED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && (m_ret > CW'(1))) |=> req_valid); // R6
endmodule

bind store_buffer store_buffer_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/store_buffer_tb.sv
module store_buffer_tb;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [TAG_W-1:0]  tag;
  } st_t;

  logic clk, rst_n;
  logic alloc_valid, alloc_ready, retire_valid, flush, req_valid, req_ack, drained;
  logic [ADDR_W-1:0] alloc_addr, req_addr;
  logic [DATA_W-1:0] alloc_data, req_data;
  logic [TAG_W-1:0]  alloc_tag, req_tag;

  int checks = 0;
  int errors = 0;
  int seq    = 0;
  bit done   = 0;
  st_t spec_q[$];
  st_t ret_q[$];

  store_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string got, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", req, got, exp);
    end
  endtask

  function automatic st_t make_store(input int n);
    st_t s;
    s.addr = 32'h1000_0000 + 32'(n * 8);
    s.data = {32'(n), ~32'(n)};
    s.tag  = TAG_W'(n);
    return s;
  endfunction

  // one cycle: drive, monitor against the scoreboard, then advance the model
  task automatic step(input bit av, input bit rv, input bit fl, input bit ack, input string req);
    st_t s, got;
    bit exp_ready;
    @(negedge clk);
    s = make_store(seq);
    alloc_valid = av; alloc_addr = s.addr; alloc_data = s.data; alloc_tag = s.tag;
    retire_valid = rv; flush = fl; req_ack = ack;
    #2;
    exp_ready = !fl && ((spec_q.size() + ret_q.size()) < DEPTH);
    check(alloc_ready == exp_ready, {req, " R4/R8 alloc_ready"},
          $sformatf("%0b", alloc_ready), $sformatf("%0b", exp_ready));
    check(req_valid == (ret_q.size() != 0), {req, " R2 req_valid"},
          $sformatf("%0b", req_valid), $sformatf("%0b", ret_q.size() != 0));
    check(drained == (ret_q.size() == 0), {req, " R9 drained"},
          $sformatf("%0b", drained), $sformatf("%0b", ret_q.size() == 0));
    if (req_valid && ret_q.size() != 0) begin
      got = {req_addr, req_data, req_tag};
      check(got == ret_q[0], {req, " R3/R10 request content"},
            $sformatf("%h", got), $sformatf("%h", ret_q[0]));
    end
    if (ack && ret_q.size() != 0) void'(ret_q.pop_front());
    if (rv && spec_q.size() != 0) ret_q.push_back(spec_q.pop_front());
    if (fl) spec_q.delete();
    else if (av && exp_ready) begin
      spec_q.push_back(s);
      seq++;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; alloc_valid = 0; retire_valid = 0; flush = 0; req_ack = 0;
    alloc_addr = '0; alloc_data = '0; alloc_tag = '0;
    repeat (3) @(posedge clk);
    #2;
    check(!req_valid && drained && alloc_ready, "R1 reset state",
          $sformatf("%0b%0b%0b", req_valid, drained, alloc_ready), "011");
    @(negedge clk); rst_n = 1'b1;

    // R2: speculative stores never requested even with ack high
    repeat (3) step(1, 0, 0, 1, "R2 spec only");
    step(0, 0, 0, 1, "R2 spec only");
    // R5: retire oldest two, drain them in order (R3)
    step(0, 1, 0, 0, "R5 retire");
    step(0, 1, 0, 0, "R5 retire");
    repeat (3) step(0, 0, 0, 1, "R3 drain");
    step(0, 1, 0, 1, "R3 drain last");
    step(0, 0, 0, 1, "R3 drain last");
    // R5: retire with nothing speculative is ignored
    step(0, 1, 0, 0, "R5 empty retire");
    // R4: fill to full, then offer more while full
    repeat (DEPTH) step(1, 0, 0, 0, "R4 fill");
    repeat (3) step(1, 0, 0, 0, "R4 full");
    // R11: retire all with the cache stalled, plus extra ignored retires (R5)
    repeat (DEPTH + 2) step(0, 1, 0, 0, "R11 hold");
    repeat (4) step(0, 0, 0, 0, "R11 hold");
    // R6: flush with retired entries pending keeps them
    step(0, 0, 1, 0, "R6 flush retired");
    repeat (DEPTH) step(0, 0, 0, 1, "R6 drain");
    // R7/R8: retire and flush together, alloc during flush
    repeat (4) step(1, 0, 0, 0, "R7 setup");
    step(1, 1, 1, 0, "R7 retire+flush");
    step(0, 0, 0, 0, "R7 after");
    step(0, 1, 0, 0, "R7 nothing left");
    repeat (2) step(0, 0, 0, 1, "R7 drain");
    // R6: flush with mix of retired and speculative, ack active
    repeat (5) step(1, 0, 0, 0, "R6 mix");
    step(0, 1, 0, 1, "R6 mix");
    step(0, 1, 0, 0, "R6 mix");
    step(1, 0, 1, 1, "R6 mix flush");
    repeat (3) step(0, 0, 0, 1, "R6 mix drain");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 23) == 0,
           ($urandom % 2) == 0, "R3 random");
    end
    repeat (DEPTH) step(0, 1, 0, 1, "R9 final drain");
    repeat (DEPTH + 2) step(0, 0, 0, 1, "R9 final drain");
    done = 1;
    finish_run();
  end
endmodule